// File: doc/BRIEF.md
# Touch Pulse Direction Qualifier

This block sits behind the two comparators of a capacitive touch front end. One comparator watches the sense channel and the other watches a matched reference channel. At the start of each sample period, marked by a one-cycle strobe, both channels begin to discharge. The block synchronizes both comparator levels into the clock domain and decides which one went low first. It then emits a single one-cycle correction pulse: an up pulse when the sense comparator wins, or a down pulse when the reference comparator wins.

The pulses also feed a run counter that tracks how many pulses in a row have had the same direction. Any reversal of direction restarts the run. A touch-detected level is raised only when the run reaches a programmable length. In equilibrium, and under slow drift, the pulses keep alternating, so the run stays short and the detect level never rises.

All pins are plain levels or strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure: a pulse is produced in the cycle it is decided and cannot be stalled.

Top module: `touch_dir_qual`

## Requirements
- R1: Each comparator input passes through two flops. When a comparator input falls while the period is armed, its pulse goes high on the third rising clock edge after the input change, provided the other input is still seen high.
- R2: A sense-first decision gives exactly one high cycle on `up_pulse`. A reference-first decision gives exactly one high cycle on `dn_pulse`. The two outputs are never high together.
- R3: A high `sample_stb` arms one decision. After a pulse or a tie, the block ignores further comparator falls until the next strobe.
- R4: If both synchronized comparators are first seen low in the same cycle, no pulse is emitted, and the run length and touch flag keep their values. A period in which neither comparator falls emits no pulse and changes nothing.
- R5: Each pulse in the same direction as the previous pulse adds one to the run length. The run length saturates at the effective threshold, which is `run_thr`, or 1 when `run_thr` is 0.
- R6: A pulse whose direction is opposite to the previous pulse restarts the run length at 1. The first pulse after reset also starts the run at 1.
- R7: `touch_det` is registered. It is high when the run length is at least the effective threshold. It updates one cycle after the pulse that changes the run. When a reversal restarts the run and the threshold is 2 or more, it falls in that same cycle.
- R8: Reset (`rst_n` low) clears the pulses, the touch flag, the run length and the remembered direction. The synchronizers reset to the high, idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe that marks the start of a sample period |
| cmp_sense | input | 1 | Asynchronous sense-channel comparator level, low once discharged |
| cmp_ref | input | 1 | Asynchronous reference-channel comparator level, low once discharged |
| run_thr | input | 6 | Run length needed for detection; 0 behaves as 1 |
| up_pulse | output | 1 | One-cycle pulse: the sense comparator fell first |
| dn_pulse | output | 1 | One-cycle pulse: the reference comparator fell first |
| touch_det | output | 1 | Qualified touch-detected level |

## Verification
Two comparator falls can be resolved in the same clock cycle. In that case the block must produce a tie rather than an up or down win. The bench provokes this by lowering both inputs on the same edge, and it compares this against falls spaced one to three cycles apart. For a tie it expects no pulse at all and an unchanged touch flag, even in the middle of a run. For a win it expects exactly one pulse, three edges after the first fall, and none for the later fall.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  localparam int unsigned THR_W_DEF = 6;
  localparam int unsigned SYNC_DEF  = 2;
endpackage

// File: rtl/tpq_sync.sv
module tpq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/tpq_arbiter.sv
module tpq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic sense_s_i,
  input  logic ref_s_i,
  output logic up_o,
  output logic dn_o
);
  logic armed_q, up_q, dn_q;
  logic sense_low, ref_low, win_up, win_dn, tie, decided;

  assign sense_low = !sense_s_i;
  assign ref_low   = !ref_s_i;
  assign win_up    = armed_q && sense_low && !ref_low;
  assign win_dn    = armed_q && ref_low && !sense_low;
  assign tie       = armed_q && sense_low && ref_low;
  assign decided   = win_up || win_dn || tie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      armed_q <= strobe_i || (armed_q && !decided);
      up_q    <= win_up;
      dn_q    <= win_dn;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_ARM_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> armed_q); // R3
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q)); // R2
  AST_DISARM_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_q || dn_q) && !$past(strobe_i)) |-> !armed_q); // R3
endmodule

// File: rtl/tpq_run_qual.sv
module tpq_run_qual
  import tpq_pkg::*;
#(
  parameter int unsigned THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             det_o
);
  localparam logic [THR_W-1:0] ONE = THR_W'(1);

  dir_e             dir_q, dir_d, pulse_dir;
  logic [THR_W-1:0] cnt_q, cnt_d, thr_eff;
  logic             det_q, pulse;

  assign thr_eff   = (thr_i == '0) ? ONE : thr_i;
  assign pulse     = up_i ^ dn_i;
  assign pulse_dir = up_i ? DIR_UP : DIR_DN;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (pulse) begin
      if (dir_q == pulse_dir) begin
        if (cnt_q < thr_eff) cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = ONE;
        dir_d = pulse_dir;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_NONE;
      det_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      det_q <= (cnt_d != '0) && (cnt_d >= thr_eff);
    end
  end

  assign det_o = det_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_i && !dn_i) |=> ($stable(cnt_q) && $stable(dir_q))); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q <= $past(thr_eff))); // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && dir_q == DIR_DN) |=> (cnt_q == ONE)); // R6
  AST_DET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((dn_i && dir_q == DIR_UP && thr_i >= THR_W'(2))) |=> !det_q); // R7
endmodule

// File: rtl/touch_dir_qual.sv
module touch_dir_qual
  import tpq_pkg::*;
#(
  parameter int unsigned THR_W       = THR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic             cmp_sense,
  input  logic             cmp_ref,
  input  logic [THR_W-1:0] run_thr,
  output logic             up_pulse,
  output logic             dn_pulse,
  output logic             touch_det
);
  localparam int unsigned N_CMP = 2;

  logic [N_CMP-1:0] cmp_raw, cmp_s;
  logic             up_w, dn_w;

  assign cmp_raw = {cmp_ref, cmp_sense};

  tpq_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_CMP), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_raw), .q_o(cmp_s)
  );

  tpq_arbiter i_arb (
    .clk(clk), .rst_n(rst_n), .strobe_i(sample_stb),
    .sense_s_i(cmp_s[0]), .ref_s_i(cmp_s[1]),
    .up_o(up_w), .dn_o(dn_w)
  );

  tpq_run_qual #(.THR_W(THR_W)) i_qual (
    .clk(clk), .rst_n(rst_n), .up_i(up_w), .dn_i(dn_w),
    .thr_i(run_thr), .det_o(touch_det)
  );

  assign up_pulse = up_w;
  assign dn_pulse = dn_w;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!up_pulse && !dn_pulse && !touch_det)); // R8
endmodule

// File: tb/test_touch_dir_qual.sv
module test_touch_dir_qual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_stb = 1'b0;
  logic       cmp_sense = 1'b1;
  logic       cmp_ref = 1'b1;
  logic [5:0] run_thr = 6'd3;
  logic       up_pulse, dn_pulse, touch_det;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int exp_cnt = 0;
  int exp_dir = 0;   // 0 none, 1 up, 2 down
  bit exp_det = 1'b0;
  int last_pat = 0;

  always #5 clk = ~clk;

  touch_dir_qual i_touch_dir_qual (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .cmp_sense(cmp_sense),
    .cmp_ref(cmp_ref), .run_thr(run_thr), .up_pulse(up_pulse),
    .dn_pulse(dn_pulse), .touch_det(touch_det)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_thr(int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic model_pulse(int dir);
    if (dir == exp_dir) begin
      if (exp_cnt < eff_thr(int'(run_thr))) exp_cnt++;
    end else begin
      exp_cnt = 1;
      exp_dir = dir;
    end
  endtask

  // pat: 0 sense first, 1 reference first, 2 both at once, 3 no fall
  task automatic run_sample(int pat, int gap);
    int ups = 0, dns = 0, first = 0;
    bit det3 = 1'b0, det4 = 1'b0, det_end;
    bit prev_det = exp_det;
    @(negedge clk) sample_stb = 1'b1;
    @(negedge clk) sample_stb = 1'b0;
    if (pat == 0 || pat == 2) cmp_sense = 1'b0;
    if (pat == 1 || pat == 2) cmp_ref = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (up_pulse) ups++;
      if (dn_pulse) dns++;
      if ((up_pulse || dn_pulse) && first == 0) first = i;
      if (i == 3) det3 = touch_det;
      if (i == 4) det4 = touch_det;
      if (i == gap) begin
        cmp_sense = 1'b0;
        cmp_ref = 1'b0;
      end
    end
    det_end = touch_det;
    cmp_sense = 1'b1;
    cmp_ref = 1'b1;
    repeat (3) @(negedge clk);
    if (pat == 0) model_pulse(1);
    if (pat == 1) model_pulse(2);
    exp_det = (exp_cnt != 0) && (exp_cnt >= eff_thr(int'(run_thr)));
    if (pat == 0) begin
      check(ups == 1 && dns == 0, "R2 up count", ups, 1);
      check(first == 3, "R1 latency", first, 3);
    end else if (pat == 1) begin
      check(dns == 1 && ups == 0, "R2 down count", dns, 1);
      check(first == 3, "R1 latency", first, 3);
    end else begin
      check(ups == 0 && dns == 0, "R4 no pulse", ups + dns, 0);
    end
    check(det3 == prev_det, "R7 detect before update", int'(det3), int'(prev_det));
    check(det4 == exp_det, "R7 detect after update", int'(det4), int'(exp_det));
    check(det_end == exp_det, "R5 R6 detect level", int'(det_end), int'(exp_det));
  endtask

  task automatic set_thr(int t);
    @(negedge clk) run_thr = 6'(t);
    exp_det = (exp_cnt != 0) && (exp_cnt >= eff_thr(t));
    repeat (2) @(negedge clk);
    check(touch_det == exp_det, "R7 threshold change", int'(touch_det), int'(exp_det));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(!up_pulse && !dn_pulse && !touch_det, "R8 reset outputs",
          int'(up_pulse) + int'(dn_pulse) + int'(touch_det), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: run of ups reaches threshold 3
    set_thr(3);
    for (int k = 0; k < 4; k++) run_sample(0, 2);
    // R4: tie and no-fall keep the run and flag
    run_sample(2, 0);
    run_sample(3, 0);
    // R6/R7: one down restarts the run and drops the flag
    run_sample(1, 1);
    run_sample(1, 3);
    run_sample(1, 1);
    // R5: threshold 0 acts as 1
    set_thr(0);
    run_sample(0, 1);
    // R3: a strobe without falls after a decision gives nothing
    run_sample(3, 0);
    // R8: reset in mid run clears state
    set_thr(2);
    run_sample(0, 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    exp_cnt = 0; exp_dir = 0; exp_det = 1'b0;
    @(negedge clk);
    check(!touch_det, "R8 detect after reset", int'(touch_det), 0);
    run_sample(0, 1);

    // random phase
    for (int n = 0; n < 300; n++) begin
      int r = int'($urandom_range(0, 99));
      int pat;
      if (n % 25 == 0) set_thr(int'($urandom_range(0, 6)));
      if (r < 60) pat = last_pat;
      else if (r < 80) pat = (last_pat == 0) ? 1 : 0;
      else if (r < 92) pat = 2;
      else pat = 3;
      if (pat < 2) last_pat = pat;
      run_sample(pat, int'($urandom_range(1, 3)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule